// File: doc/BRIEF.md
# Domain-Tagged Translation Lookaside Cache

This block is the small cache that an I/O address translation unit consults on every device memory request before it starts a page-table walk. It holds a handful of recent mappings from a device's virtual page to a physical page. Each mapping carries the isolation domain it belongs to, the requester that caused it to be loaded, its page size and its read/write permissions. A lookup presents a domain, a virtual page number and an access type. Exactly one cycle later the block reports hit or miss, the physical page number, the page size, the permission bits, and whether the access type is allowed. The walker is started only on a miss.

Walk results are written through a fill port. A separate invalidation port removes stale mappings when the tables change. It can remove every entry, every entry of one domain, every entry loaded by one requester, or the entries of one domain that cover one virtual page. 4 KB, 2 MB and 1 GB mappings sit side by side in the same eight fully associative entries. Each entry compares only the virtual bits that lie above its own page size.

Top module: `xc_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high is answered on the following clock edge. `rsp_valid` is high for exactly that one cycle, and the result reflects the entries as they stood when the lookup was presented.
- R2: A lookup hits only on a valid entry whose domain tag equals `lk_dom`. The requester ID of a fill is recorded for invalidation only and takes no part in hit detection.
- R3: Page size is encoded 0 = 4 KB, 1 = 2 MB, 2 = 1 GB; code 3 behaves as 4 KB. An entry ignores the low 0, 9 or 18 virtual page bits for these sizes. On a hit, `rsp_ppn` takes those same low bits from the request's virtual page number.
- R4: Permission bit 0 grants read and bit 1 grants write. `rsp_allow` is high only on a hit whose permission covers the access (`lk_write` = 1 for a write). On a miss, `rsp_ppn`, `rsp_size`, `rsp_perm` and `rsp_allow` are all zero.
- R5: `inv_kind` selects what an invalidation removes: 0 removes every entry, 1 removes entries whose domain equals `inv_dom`, 2 removes entries whose requester equals `inv_rid`, and 3 removes the entries of domain `inv_dom` whose page covers `inv_vpn`.
- R6: An invalidation takes effect in the cycle it is presented. A lookup in that same cycle does not hit any entry the invalidation removes.
- R7: A fill whose domain, page size and size-aligned page equal those of a valid entry overwrites that entry, so no duplicate is created.
- R8: Any other fill takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after entry 7, each time it is used.
- R9: After reset no entry is valid and `rsp_valid` is low.
- R10: When several entries hit, the lowest-numbered one answers. A fill and an invalidation in the same cycle leave the filled entry valid. A lookup in the same cycle as a fill does not see that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_dom | input | 4 | Domain of the requesting device |
| lk_vpn | input | 36 | Virtual page number (4 KB granularity) |
| lk_write | input | 1 | Access type: 1 = write, 0 = read |
| fill_valid | input | 1 | Fill strobe from the table walker |
| fill_dom | input | 4 | Domain tag of the new mapping |
| fill_rid | input | 8 | Requester ID that caused the walk |
| fill_vpn | input | 36 | Virtual page of the mapping |
| fill_ppn | input | 28 | Physical page of the mapping |
| fill_size | input | 2 | Page size code |
| fill_perm | input | 2 | Permission bits (bit 0 read, bit 1 write) |
| inv_valid | input | 1 | Invalidation strobe |
| inv_kind | input | 2 | Invalidation selector |
| inv_dom | input | 4 | Domain for kinds 1 and 3 |
| inv_rid | input | 8 | Requester for kind 2 |
| inv_vpn | input | 36 | Virtual page for kind 3 |
| rsp_valid | output | 1 | Lookup answer strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 28 | Physical page of the hit |
| rsp_size | output | 2 | Page size of the hit |
| rsp_perm | output | 2 | Permission bits of the hit |
| rsp_allow | output | 1 | Hit with permission for the access type |

## Verification
The bench targets large-page offsets. A design that compared all virtual bits on a 2 MB or 1 GB entry, or failed to merge the request offset into the physical page, would miss or return the base page. It sets a lookup against an invalidation in the same cycle, where a design that applied the invalidation one cycle late would still report a hit. It re-fills an existing mapping and then fills past capacity. A design that made duplicates, or let the round-robin pointer win over a free entry, would evict a mapping that should still be present. Overlapping 4 KB and 2 MB entries, together with a long random stream over a small address and domain space, expose any wrong hit priority or cross-domain hit.

// File: rtl/xc_pkg.sv
package xc_pkg;

    parameter int XC_ENTRIES = 8;
    parameter int DOM_W      = 4;
    parameter int RID_W      = 8;
    parameter int VPN_W      = 36;
    parameter int PPN_W      = 28;
    parameter int LVL_W      = 9;   // page-number bits resolved per table level

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_2M   = 2'd1,
        PG_1G   = 2'd2,
        PG_RSVD = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        INV_ALL  = 2'd0,
        INV_DOM  = 2'd1,
        INV_RID  = 2'd2,
        INV_PAGE = 2'd3
    } inv_kind_e;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic [RID_W-1:0] rid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        pg_size_e         size;
        logic [1:0]       perm;
    } entry_t;

    // Ones on the virtual page bits a mapping of this size does not compare.
    function automatic logic [VPN_W-1:0] vpn_low_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        m = '0;
        case (s)
            PG_2M:   m[LVL_W-1:0]   = '1;
            PG_1G:   m[2*LVL_W-1:0] = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [PPN_W-1:0] ppn_low_mask(pg_size_e s);
        logic [PPN_W-1:0] m;
        m = '0;
        case (s)
            PG_2M:   m[LVL_W-1:0]   = '1;
            PG_1G:   m[2*LVL_W-1:0] = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Physical page of a hit: stored base plus the request's in-page offset.
    function automatic logic [PPN_W-1:0] merge_ppn(logic [PPN_W-1:0] base,
                                                   logic [VPN_W-1:0] vpn,
                                                   pg_size_e s);
        logic [PPN_W-1:0] m;
        m = ppn_low_mask(s);
        return (base & ~m) | (vpn[PPN_W-1:0] & m);
    endfunction

endpackage

// File: rtl/xc_entry.sv
module xc_entry
    import xc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  entry_t           wr_data,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [DOM_W-1:0] fl_dom,
    input  logic [VPN_W-1:0] fl_vpn,
    input  pg_size_e         fl_size,
    input  logic             inv_en,
    input  inv_kind_e        inv_kind,
    input  logic [DOM_W-1:0] inv_dom,
    input  logic [RID_W-1:0] inv_rid,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             vld,
    output logic             lk_match,
    output logic             dup_match,
    output logic             kill,
    output entry_t           data
);

    logic [VPN_W-1:0] low_m;
    logic             sel;

    assign low_m = vpn_low_mask(data.size);

    always_comb begin
        lk_match  = vld && (data.dom == lk_dom) && ((lk_vpn & ~low_m) == data.vpn);
        dup_match = vld && (data.dom == fl_dom) && (data.size == fl_size)
                        && (data.vpn == fl_vpn);
    end

    always_comb begin
        case (inv_kind)
            INV_ALL:  sel = 1'b1;
            INV_DOM:  sel = (data.dom == inv_dom);
            INV_RID:  sel = (data.rid == inv_rid);
            INV_PAGE: sel = (data.dom == inv_dom) && ((inv_vpn & ~low_m) == data.vpn);
            default:  sel = 1'b0;
        endcase
        kill = inv_en && vld && sel;
    end

    // Fill wins over a same-cycle invalidation of this slot.
    always_ff @(posedge clk) begin
        if (rst)        vld <= 1'b0;
        else if (wr_en) vld <= 1'b1;
        else if (kill)  vld <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) data <= wr_data;
    end

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill_valid,
    input  logic [N-1:0]  valid_vec,
    input  logic [N-1:0]  dup_vec,
    output logic [IW-1:0] sel
);

    logic [IW-1:0] ptr;
    logic [IW-1:0] dup_idx;
    logic [IW-1:0] free_idx;
    logic          dup_any;
    logic          free_any;

    always_comb begin
        dup_any  = 1'b0;
        free_any = 1'b0;
        dup_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup_vec[i]) begin
                dup_any = 1'b1;
                dup_idx = IW'(i);
            end
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        sel = dup_any ? dup_idx : (free_any ? free_idx : ptr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (fill_valid && !dup_any && !free_any) begin
            ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xc_cache.sv
module xc_cache
    import xc_pkg::*;
#(
    parameter int NUM_ENTRIES = XC_ENTRIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             fill_valid,
    input  logic [DOM_W-1:0] fill_dom,
    input  logic [RID_W-1:0] fill_rid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_size,
    input  logic [1:0]       fill_perm,
    input  logic             inv_valid,
    input  logic [1:0]       inv_kind,
    input  logic [DOM_W-1:0] inv_dom,
    input  logic [RID_W-1:0] inv_rid,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [1:0]       rsp_size,
    output logic [1:0]       rsp_perm,
    output logic             rsp_allow
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] match_vec;
    logic [NUM_ENTRIES-1:0] dup_vec;
    logic [NUM_ENTRIES-1:0] kill_vec;
    entry_t                 ent [NUM_ENTRIES];
    entry_t                 fill_ent;
    pg_size_e               fsz;
    logic [IDX_W-1:0]       victim;
    logic [IDX_W-1:0]       hit_idx;
    logic                   hit_any;
    entry_t                 hit_ent;

    assign fsz = pg_size_e'(fill_size);

    always_comb begin
        fill_ent.dom  = fill_dom;
        fill_ent.rid  = fill_rid;
        fill_ent.vpn  = fill_vpn & ~vpn_low_mask(fsz);
        fill_ent.ppn  = fill_ppn & ~ppn_low_mask(fsz);
        fill_ent.size = fsz;
        fill_ent.perm = fill_perm;
    end

    xc_victim #(
        .N  (NUM_ENTRIES),
        .IW (IDX_W)
    ) u_victim (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .valid_vec  (valid_vec),
        .dup_vec    (dup_vec),
        .sel        (victim)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        xc_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (fill_valid && (victim == IDX_W'(g))),
            .wr_data   (fill_ent),
            .lk_dom    (lk_dom),
            .lk_vpn    (lk_vpn),
            .fl_dom    (fill_dom),
            .fl_vpn    (fill_ent.vpn),
            .fl_size   (fsz),
            .inv_en    (inv_valid),
            .inv_kind  (inv_kind_e'(inv_kind)),
            .inv_dom   (inv_dom),
            .inv_rid   (inv_rid),
            .inv_vpn   (inv_vpn),
            .vld       (valid_vec[g]),
            .lk_match  (match_vec[g]),
            .dup_match (dup_vec[g]),
            .kill      (kill_vec[g]),
            .data      (ent[g])
        );
    end

    // Lowest-numbered surviving match answers.
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i] && !kill_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_ent = ent[hit_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_size  <= '0;
            rsp_perm  <= '0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid && hit_any) begin
                rsp_hit   <= 1'b1;
                rsp_ppn   <= merge_ppn(hit_ent.ppn, lk_vpn, hit_ent.size);
                rsp_size  <= hit_ent.size;
                rsp_perm  <= hit_ent.perm;
                rsp_allow <= lk_write ? hit_ent.perm[1] : hit_ent.perm[0];
            end else begin
                rsp_hit   <= 1'b0;
                rsp_ppn   <= '0;
                rsp_size  <= '0;
                rsp_perm  <= '0;
                rsp_allow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic         fill_valid,
    input logic         inv_valid,
    input logic [1:0]   inv_kind,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         rsp_allow,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] dup_vec
);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R1
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R4
    allow_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_allow |-> (rsp_hit && rsp_valid));

    // R6
    same_cycle_flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && inv_valid && inv_kind == 2'd0) |=> !rsp_hit);

    // R5
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'd0 && !fill_valid) |=> (valid_vec == '0));

    // R10
    fill_beats_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'd0 && fill_valid) |=> ($countones(valid_vec) == 1));

    // R7
    dup_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !inv_valid && dup_vec != '0)
        |=> ($countones(valid_vec) == $past($countones(valid_vec))));

    // R8
    free_slot_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !inv_valid && dup_vec == '0 && !(&valid_vec))
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    // R7
    single_dup_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dup_vec));

endmodule

bind xc_cache xc_checker #(.N(NUM_ENTRIES)) u_xc_checker (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .fill_valid (fill_valid),
    .inv_valid  (inv_valid),
    .inv_kind   (inv_kind),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_allow  (rsp_allow),
    .valid_vec  (valid_vec),
    .dup_vec    (dup_vec)
);

// File: tb/test_xc_cache.sv
`timescale 1ns/1ps
module test_xc_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_write = 0;
    logic [3:0]  lk_dom = 0;
    logic [35:0] lk_vpn = 0;
    logic        fill_valid = 0;
    logic [3:0]  fill_dom = 0;
    logic [7:0]  fill_rid = 0;
    logic [35:0] fill_vpn = 0;
    logic [27:0] fill_ppn = 0;
    logic [1:0]  fill_size = 0, fill_perm = 0;
    logic        inv_valid = 0;
    logic [1:0]  inv_kind = 0;
    logic [3:0]  inv_dom = 0;
    logic [7:0]  inv_rid = 0;
    logic [35:0] inv_vpn = 0;
    logic        rsp_valid, rsp_hit, rsp_allow;
    logic [27:0] rsp_ppn;
    logic [1:0]  rsp_size, rsp_perm;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    xc_cache i_xc_cache (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_dom(lk_dom), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_dom(fill_dom), .fill_rid(fill_rid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
        .fill_perm(fill_perm),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_dom(inv_dom),
        .inv_rid(inv_rid), .inv_vpn(inv_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_size(rsp_size), .rsp_perm(rsp_perm), .rsp_allow(rsp_allow)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_v    [8];
    logic [3:0]  m_dom  [8];
    logic [7:0]  m_rid  [8];
    logic [35:0] m_vpn  [8];
    logic [27:0] m_ppn  [8];
    logic [1:0]  m_sz   [8];
    logic [1:0]  m_perm [8];
    int          m_ptr;
    bit          e_v, e_h, e_a;
    logic [27:0] e_ppn;
    logic [1:0]  e_sz, e_perm;

    function automatic int low_bits(logic [1:0] s);
        return (s == 2'd1) ? 9 : ((s == 2'd2) ? 18 : 0);
    endfunction

    function automatic logic [35:0] vbase(logic [35:0] v, logic [1:0] s);
        return (v >> low_bits(s)) << low_bits(s);
    endfunction

    function automatic bit killed(int i);
        if (!inv_valid || !m_v[i]) return 0;
        case (inv_kind)
            2'd0: return 1;
            2'd1: return m_dom[i] == inv_dom;
            2'd2: return m_rid[i] == inv_rid;
            default: return (m_dom[i] == inv_dom) && (vbase(inv_vpn, m_sz[i]) == m_vpn[i]);
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_v[i] = 0;
            m_ptr = 0;
            e_v = 0; e_h = 0; e_a = 0; e_ppn = 0; e_sz = 0; e_perm = 0;
        end else begin
            int slot;
            int lb;
            e_v = lk_valid; e_h = 0; e_a = 0; e_ppn = 0; e_sz = 0; e_perm = 0;
            if (lk_valid) begin
                for (int i = 0; i < 8; i++) begin
                    if (!e_h && m_v[i] && m_dom[i] == lk_dom &&
                        vbase(lk_vpn, m_sz[i]) == m_vpn[i] && !killed(i)) begin
                        e_h    = 1;
                        lb     = low_bits(m_sz[i]);
                        e_ppn  = m_ppn[i] | (lk_vpn[27:0] & ((28'd1 << lb) - 28'd1));
                        e_sz   = m_sz[i];
                        e_perm = m_perm[i];
                        e_a    = lk_write ? m_perm[i][1] : m_perm[i][0];
                    end
                end
            end
            slot = -1;
            for (int i = 0; i < 8; i++)
                if (slot < 0 && m_v[i] && m_dom[i] == fill_dom && m_sz[i] == fill_size &&
                    m_vpn[i] == vbase(fill_vpn, fill_size)) slot = i;
            for (int i = 0; i < 8; i++)
                if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                if (fill_valid) m_ptr = (m_ptr + 1) % 8;
            end
            for (int i = 0; i < 8; i++) if (killed(i)) m_v[i] = 0;
            if (fill_valid) begin
                m_v[slot]    = 1;
                m_dom[slot]  = fill_dom;
                m_rid[slot]  = fill_rid;
                m_vpn[slot]  = vbase(fill_vpn, fill_size);
                m_ppn[slot]  = (fill_ppn >> low_bits(fill_size)) << low_bits(fill_size);
                m_sz[slot]   = fill_size;
                m_perm[slot] = fill_perm;
            end
        end
    end

    // Every-cycle comparison against the model (R1 timing, all fields).
    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (rsp_valid !== e_v || (e_v && (rsp_hit !== e_h || rsp_ppn !== e_ppn ||
                rsp_size !== e_sz || rsp_perm !== e_perm || rsp_allow !== e_a))) begin
                n_fail++;
                $display("FAIL R1 model cycle %0d: got v%0b h%0b ppn %h sz %0d perm %0d a%0b, expected v%0b h%0b ppn %h sz %0d perm %0d a%0b",
                         cyc, rsp_valid, rsp_hit, rsp_ppn, rsp_size, rsp_perm, rsp_allow,
                         e_v, e_h, e_ppn, e_sz, e_perm, e_a);
            end
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cyc);
            report();
        end
    end

    // ---------------- directed stimulus helpers ----------------
    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic set_fill(logic [3:0] d, logic [7:0] r, logic [35:0] v,
                            logic [27:0] p, logic [1:0] s, logic [1:0] pm);
        fill_valid = 1; fill_dom = d; fill_rid = r; fill_vpn = v;
        fill_ppn = p; fill_size = s; fill_perm = pm;
    endtask

    task automatic fill(logic [3:0] d, logic [7:0] r, logic [35:0] v,
                        logic [27:0] p, logic [1:0] s, logic [1:0] pm);
        set_fill(d, r, v, p, s, pm);
        step();
    endtask

    task automatic set_inv(logic [1:0] k, logic [3:0] d, logic [7:0] r, logic [35:0] v);
        inv_valid = 1; inv_kind = k; inv_dom = d; inv_rid = r; inv_vpn = v;
    endtask

    task automatic inv(logic [1:0] k, logic [3:0] d, logic [7:0] r, logic [35:0] v);
        set_inv(k, d, r, v);
        step();
    endtask

    task automatic set_look(logic [3:0] d, logic [35:0] v, logic w);
        lk_valid = 1; lk_dom = d; lk_vpn = v; lk_write = w;
    endtask

    task automatic look(logic [3:0] d, logic [35:0] v, logic w);
        set_look(d, v, w);
        step();
    endtask

    task automatic expect_hit(string tag, logic [27:0] p, logic [1:0] s);
        chk(rsp_valid && rsp_hit && rsp_ppn == p && rsp_size == s, tag,
            {rsp_hit, 2'b0, rsp_size, rsp_ppn}, {1'b1, 2'b0, s, p});
    endtask

    task automatic expect_miss(string tag);
        chk(rsp_valid && !rsp_hit && rsp_ppn == 0 && rsp_perm == 0 && !rsp_allow, tag,
            {rsp_hit, rsp_allow, rsp_perm, rsp_ppn}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rsp_valid == 0, "R9 rsp_valid after reset", rsp_valid, 0);
        rst = 0;
        look(1, 36'h12345, 0);
        expect_miss("R9 empty after reset");

        // R2 / R3 / R4 basics
        fill(1, 8'd5, 36'h12345, 28'h0ABC, 2'd0, 2'b11);
        look(1, 36'h12345, 1);
        expect_hit("R2 4K hit same domain", 28'h0ABC, 2'd0);
        chk(rsp_allow && rsp_perm == 2'b11, "R4 write allowed rw", rsp_allow, 1);
        look(2, 36'h12345, 0);
        expect_miss("R2 other domain misses");
        look(1, 36'h12344, 0);
        expect_miss("R3 4K compares all bits");

        fill(1, 8'd6, 36'h004A3, 28'h2000, 2'd1, 2'b01);
        look(1, 36'h004A7, 0);
        expect_hit("R3 2M hit with offset", 28'h20A7, 2'd1);
        chk(rsp_allow, "R4 read on read-only", rsp_allow, 1);
        look(1, 36'h004A7, 1);
        chk(rsp_hit && !rsp_allow, "R4 write on read-only denied", rsp_allow, 0);
        look(1, 36'h00600, 0);
        expect_miss("R3 2M next region misses");

        fill(3, 8'd7, 36'h80000, 28'h0C0000, 2'd2, 2'b10);
        look(3, 36'h8ABCD, 1);
        expect_hit("R3 1G hit with offset", 28'h0CABCD, 2'd2);
        look(3, 36'hC0000, 0);
        expect_miss("R3 1G other region misses");

        // R5 / R6
        set_inv(2'd1, 3, 0, 0); set_look(3, 36'h8ABCD, 0); step();
        expect_miss("R6 lookup during domain invalidate");
        look(1, 36'h12345, 0);
        expect_hit("R5 other domain survives", 28'h0ABC, 2'd0);
        inv(2'd2, 0, 8'd6, 0);
        look(1, 36'h004A7, 0);
        expect_miss("R5 requester invalidate");
        look(1, 36'h12345, 0);
        expect_hit("R5 other requester survives", 28'h0ABC, 2'd0);
        set_inv(2'd3, 1, 0, 36'h12345); set_look(1, 36'h12345, 0); step();
        expect_miss("R6 lookup during page invalidate");
        fill(1, 8'd6, 36'h00400, 28'h2000, 2'd1, 2'b01);
        inv(2'd3, 1, 0, 36'h004FF);
        look(1, 36'h00400, 0);
        expect_miss("R5 page invalidate hits covering 2M");
        fill(4, 8'd1, 36'h1, 28'h1, 2'd0, 2'b01);
        inv(2'd0, 0, 0, 0);
        look(4, 36'h1, 0);
        expect_miss("R5 invalidate all");

        // R7 / R8
        fill(1, 8'd1, 36'h10, 28'h1, 2'd0, 2'b01);
        fill(1, 8'd2, 36'h10, 28'h2, 2'd0, 2'b01);
        look(1, 36'h10, 0);
        expect_hit("R7 refill overwrites", 28'h2, 2'd0);
        for (int k = 2; k <= 8; k++) fill(1, 8'd3, 36'(k * 16), 28'(k), 2'd0, 2'b01);
        for (int k = 2; k <= 8; k++) begin
            look(1, 36'(k * 16), 0);
            expect_hit("R7 no duplicate, all resident", 28'(k), 2'd0);
        end
        fill(1, 8'd3, 36'h90, 28'h9, 2'd0, 2'b01);
        look(1, 36'h10, 0);
        expect_miss("R8 round-robin evicts entry 0");
        fill(1, 8'd3, 36'hA0, 28'hA, 2'd0, 2'b01);
        look(1, 36'h20, 0);
        expect_miss("R8 pointer advanced to entry 1");
        inv(2'd3, 1, 0, 36'h50);
        fill(1, 8'd3, 36'hB0, 28'hB, 2'd0, 2'b01);
        look(1, 36'h30, 0);
        expect_hit("R8 free entry preferred over pointer", 28'h3, 2'd0);
        look(1, 36'hB0, 0);
        expect_hit("R8 fill placed in free entry", 28'hB, 2'd0);

        // R10
        inv(2'd0, 0, 0, 0);
        fill(1, 8'd1, 36'h200, 28'h1000, 2'd1, 2'b01);
        fill(1, 8'd1, 36'h205, 28'h0777, 2'd0, 2'b01);
        look(1, 36'h205, 0);
        expect_hit("R10 lowest entry wins (2M)", 28'h1005, 2'd1);
        inv(2'd0, 0, 0, 0);
        fill(1, 8'd1, 36'h205, 28'h0777, 2'd0, 2'b01);
        fill(1, 8'd1, 36'h200, 28'h1000, 2'd1, 2'b01);
        look(1, 36'h205, 0);
        expect_hit("R10 lowest entry wins (4K)", 28'h0777, 2'd0);
        set_fill(2, 8'd1, 36'h300, 28'h33, 2'd0, 2'b01); set_look(2, 36'h300, 0); step();
        expect_miss("R10 lookup does not see same-cycle fill");
        look(2, 36'h300, 0);
        expect_hit("R10 fill visible next cycle", 28'h33, 2'd0);
        set_fill(5, 8'd1, 36'h400, 28'h44, 2'd0, 2'b01); set_inv(2'd0, 0, 0, 0); step();
        look(5, 36'h400, 0);
        expect_hit("R10 fill survives same-cycle invalidate", 28'h44, 2'd0);
        look(1, 36'h205, 0);
        expect_miss("R10 invalidate still removes others");

        // Random stream, checked by the model every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [35:0] v;
            v = (36'($urandom_range(0, 1)) << 18) | (36'($urandom_range(0, 1)) << 9)
              | 36'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) set_look(4'($urandom_range(0, 2)), v, 1'($urandom_range(0, 1)));
            v = (36'($urandom_range(0, 1)) << 18) | (36'($urandom_range(0, 1)) << 9)
              | 36'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0)
                set_fill(4'($urandom_range(0, 2)), 8'($urandom_range(0, 3)), v,
                         28'($urandom), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 15) == 0)
                set_inv(2'($urandom_range(0, 3)), 4'($urandom_range(0, 2)),
                        8'($urandom_range(0, 3)), 36'($urandom_range(0, 3)) | (36'($urandom_range(0, 1)) << 18));
            step();
        end
        step();
        report();
    end

endmodule